// File: doc/BRIEF.md
# Fault Record Queue Writer

This block sits at the end of an I/O translation path. Each time the path reports a fault, the block turns the event into a fixed 32-byte record and stores it in a circular queue in system memory. The memory write port is a simple one that takes 64 bits per cycle, so the block emits a record as four consecutive word writes. Hardware owns the queue's tail pointer and advances it only after all four words of a record have gone out. Software owns the head pointer and moves it as it consumes records.

The queue's location and its size (as a log2 of the entry count) come from configuration inputs. When the queue has no free slot, an incoming fault is discarded and a sticky overflow flag is raised. Every stored record sets a fault-pending interrupt bit, which software clears by writing one to it. While the enable is low, the queue is off: faults are discarded, the tail returns to slot zero and the overflow flag is cleared.

The block takes one event at a time. It lowers its ready output while a record is being written, and the translation path holds its event until ready returns.

Top module: `fltq_writer`

## Requirements
- R1: Word 0 of a record (byte offset 0) holds cause in bits [11:0], transaction type in [17:12], privilege in bit 18, a zero in bit 19, PASID-valid in bit 20, the 20-bit PASID in [40:21] and the low 23 bits of the device ID in [63:41].
- R2: Word 1 (offset 8) holds the four address-present flags in bits [3:0] and zero in bits [63:4].
- R3: Word 2 (offset 16) holds the fault address. Word 3 (offset 24) holds the guest-physical address only when the cause is 21 or 23, and is zero for every other cause (for example 1, 5, 7, 12, 13, 15, 256, 258, 259, 260).
- R4: An accepted, stored event produces exactly four write cycles, back to back. They begin in the cycle after acceptance, in word order 0,1,2,3, at address base + tail*32 + word*8. Ready is low during them.
- R5: The tail advances by one, modulo 2^log2size, at the clock edge that ends the fourth write, and at no other time. Log2 size values above MAX_LOG2N are treated as MAX_LOG2N.
- R6: The queue is full when (tail+1) mod 2^log2size equals head. An event accepted while the queue is full produces no write and leaves the tail unchanged, and the overflow flag goes high at the next edge and stays high.
- R7: The fault-pending bit goes high at the edge that completes a record. A one-cycle pulse on the clear input lowers it at the next edge, unless a record completes at that same edge, in which case it stays high.
- R8: While enable is low, events cause no writes, the tail is held at zero and the overflow flag is cleared. A record in progress is abandoned without advancing the tail.
- R9: After synchronous reset, the tail is zero, overflow and fault-pending are low, no write is issued and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Queue on |
| evt_valid | input | 1 | Fault event present |
| evt_ready | output | 1 | Writer idle, event taken when valid |
| evt_cause | input | 12 | Fault cause code |
| evt_ttyp | input | 6 | Transaction type code (1..9) |
| evt_priv | input | 1 | Privileged access |
| evt_pv | input | 1 | PASID valid |
| evt_pasid | input | 20 | Process address space ID |
| evt_devid | input | 24 | Device ID |
| evt_flags | input | 4 | Address-present flags |
| evt_addr | input | 64 | Faulting address |
| evt_gpa | input | 64 | Guest-physical address |
| cfg_base | input | ADDR_W | Queue base address, 32-byte aligned |
| cfg_log2n | input | LOG2_W | Log2 of entry count |
| sw_head | input | MAX_LOG2N | Software head index |
| ip_clr | input | 1 | Write-one-to-clear for fault-pending |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 64 | Memory write data |
| tail | output | MAX_LOG2N | Hardware tail index |
| overflow | output | 1 | Sticky overflow flag |
| fault_pending | output | 1 | Fault interrupt pending |

## Verification
The cycle-level properties are checked on every clock. These cover the bit 19 zero in word 0, the zero upper bits of word 1, and the 8-byte address step between back-to-back write beats. They also cover ready staying low while a write is active, the tail moving only by one (or wrapping to zero) and only right after a fourth beat, the overflow flag holding, fault-pending rising after each completed record, and the absence of writes while the queue is off. Other behaviours need the bench's scenarios. These are the exact field contents for the various cause and type codes, the full threshold against a software head, the dropping of a fault into a full queue, the wrap of the tail, the write-one-to-clear race, and the resets that disabling the queue performs.

// File: rtl/fltq_pkg.sv
package fltq_pkg;

    localparam int WORD_W  = 64;
    localparam int CAUSE_W = 12;
    localparam int TTYP_W  = 6;
    localparam int PASID_W = 20;
    localparam int DEVID_W = 24;
    localparam int FLAG_W  = 4;
    localparam int BEATS   = 4;
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int REC_BYTES_LOG2  = 5;
    localparam int WORD_BYTES_LOG2 = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CZ_FETCH_ACC   = 12'd1,
        CZ_LOAD_ACC    = 12'd5,
        CZ_STORE_ACC   = 12'd7,
        CZ_FETCH_PF    = 12'd12,
        CZ_LOAD_PF     = 12'd13,
        CZ_STORE_PF    = 12'd15,
        CZ_LOAD_GPF    = 12'd21,
        CZ_STORE_GPF   = 12'd23,
        CZ_ALL_BLOCKED = 12'd256,
        CZ_DC_INVALID  = 12'd258,
        CZ_DC_MISCFG   = 12'd259,
        CZ_TTYP_DENIED = 12'd260
    } fault_cause_e;

    typedef enum logic [TTYP_W-1:0] {
        TT_UT_READ  = 6'd1,
        TT_UT_WRITE = 6'd2,
        TT_UT_FETCH = 6'd3,
        TT_TR_READ  = 6'd4,
        TT_TR_WRITE = 6'd5,
        TT_TR_FETCH = 6'd6,
        TT_ATS_REQ  = 6'd7,
        TT_MSG_REQ  = 6'd8,
        TT_PAGE_REQ = 6'd9
    } xact_type_e;

    typedef enum logic [BEAT_W-1:0] {
        BEAT_W0 = 2'd0,
        BEAT_W1 = 2'd1,
        BEAT_W2 = 2'd2,
        BEAT_W3 = 2'd3
    } beat_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [TTYP_W-1:0]  ttyp;
        logic               priv;
        logic               pv;
        logic [PASID_W-1:0] pasid;
        logic [DEVID_W-1:0] devid;
        logic [FLAG_W-1:0]  flags;
        logic [WORD_W-1:0]  addr;
        logic [WORD_W-1:0]  gpa;
    } fault_evt_t;

    function automatic logic is_gstage(logic [CAUSE_W-1:0] c);
        return (c == CZ_LOAD_GPF) || (c == CZ_STORE_GPF);
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(fault_evt_t e, beat_e b);
        logic [WORD_W-1:0] w;
        case (b)
            BEAT_W0: w = {e.devid[DEVID_W-2:0], e.pasid, e.pv, 1'b0,
                          e.priv, e.ttyp, e.cause};
            BEAT_W1: w = {{(WORD_W-FLAG_W){1'b0}}, e.flags};
            BEAT_W2: w = e.addr;
            default: w = is_gstage(e.cause) ? e.gpa : '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fltq_rec_pack.sv
module fltq_rec_pack
    import fltq_pkg::*;
(
    input  fault_evt_t        rec,
    input  beat_e             beat,
    output logic [WORD_W-1:0] word
);
    always_comb word = pack_word(rec, beat);
endmodule

// File: rtl/fltq_tail_ctl.sv
module fltq_tail_ctl #(
    parameter int MAX_LOG2N = 8,
    localparam int IDX_W  = MAX_LOG2N,
    localparam int LOG2_W = $clog2(MAX_LOG2N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LOG2_W-1:0] cfg_log2n,
    input  logic [IDX_W-1:0]  sw_head,
    input  logic              advance,
    output logic [IDX_W-1:0]  tail,
    output logic              full
);
    logic [LOG2_W-1:0] eff_log2n;
    logic [IDX_W-1:0]  mask;
    logic [IDX_W-1:0]  tail_nxt;

    always_comb begin
        eff_log2n = (cfg_log2n > LOG2_W'(MAX_LOG2N)) ? LOG2_W'(MAX_LOG2N) : cfg_log2n;
        mask      = {IDX_W{1'b1}} >> (IDX_W - int'(eff_log2n));
        tail_nxt  = (tail + 1'b1) & mask;
        full      = (tail_nxt == (sw_head & mask));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            tail <= '0;
        end else if (advance) begin
            tail <= tail_nxt;
        end
    end
endmodule

// File: rtl/fltq_beat_seq.sv
module fltq_beat_seq
    import fltq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  start,
    output logic  busy,
    output beat_e beat,
    output logic  last
);
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            busy <= 1'b0;
            beat <= BEAT_W0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                beat <= BEAT_W0;
            end
        end else if (beat == BEAT_W3) begin
            busy <= 1'b0;
            beat <= BEAT_W0;
        end else begin
            beat <= beat_e'(beat + 1'b1);
        end
    end

    assign last = busy && enable && (beat == BEAT_W3);
endmodule

// File: rtl/fltq_writer.sv
module fltq_writer
    import fltq_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int MAX_LOG2N = 8,
    localparam int IDX_W  = MAX_LOG2N,
    localparam int LOG2_W = $clog2(MAX_LOG2N + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               evt_valid,
    output logic               evt_ready,
    input  logic [11:0]        evt_cause,
    input  logic [5:0]         evt_ttyp,
    input  logic               evt_priv,
    input  logic               evt_pv,
    input  logic [19:0]        evt_pasid,
    input  logic [23:0]        evt_devid,
    input  logic [3:0]         evt_flags,
    input  logic [63:0]        evt_addr,
    input  logic [63:0]        evt_gpa,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [LOG2_W-1:0]  cfg_log2n,
    input  logic [IDX_W-1:0]   sw_head,
    input  logic               ip_clr,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [63:0]        mem_wr_data,
    output logic [IDX_W-1:0]   tail,
    output logic               overflow,
    output logic               fault_pending
);
    fault_evt_t rec_q;
    logic       busy, last, full, accept, store, drop;
    beat_e      beat;

    assign evt_ready = !busy;
    assign accept    = evt_valid && evt_ready && enable;
    assign store     = accept && !full;
    assign drop      = accept && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (store) begin
            rec_q <= '{cause: evt_cause, ttyp: evt_ttyp, priv: evt_priv,
                       pv: evt_pv, pasid: evt_pasid, devid: evt_devid,
                       flags: evt_flags, addr: evt_addr, gpa: evt_gpa};
        end
    end

    fltq_beat_seq seq_i (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .start  (store),
        .busy   (busy),
        .beat   (beat),
        .last   (last)
    );

    fltq_tail_ctl #(.MAX_LOG2N(MAX_LOG2N)) tail_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cfg_log2n (cfg_log2n),
        .sw_head   (sw_head),
        .advance   (last),
        .tail      (tail),
        .full      (full)
    );

    fltq_rec_pack pack_i (
        .rec  (rec_q),
        .beat (beat),
        .word (mem_wr_data)
    );

    assign mem_wr_en   = busy && enable;
    assign mem_wr_addr = cfg_base
                       + (ADDR_W'(tail) << REC_BYTES_LOG2)
                       + (ADDR_W'(beat) << WORD_BYTES_LOG2);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            overflow <= 1'b0;
        end else if (drop) begin
            overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_pending <= 1'b0;
        end else if (last) begin
            fault_pending <= 1'b1;
        end else if (ip_clr) begin
            fault_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/fltq_writer_chk.sv
module fltq_writer_chk #(
    parameter int ADDR_W    = 64,
    parameter int MAX_LOG2N = 8,
    localparam int IDX_W = MAX_LOG2N
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              evt_ready,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [63:0]       mem_wr_data,
    input logic [IDX_W-1:0]  tail,
    input logic              overflow,
    input logic              fault_pending
);
    a_r1_bit19_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr[4:3] == 2'd0) |-> (mem_wr_data[19] == 1'b0));

    a_r2_word1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr[4:3] == 2'd1) |-> (mem_wr_data[63:4] == '0));

    a_r4_beat_step: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr[4:3] != 2'd0)
        |-> ($past(mem_wr_en) && mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(8)));

    a_r4_not_ready_while_writing: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !evt_ready);

    a_r5_tail_step: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && tail != $past(tail))
        |-> ((tail == $past(tail) + 1'b1) || (tail == '0)));

    a_r5_tail_after_last_beat: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && tail != $past(tail))
        |-> ($past(mem_wr_en) && $past(mem_wr_addr[4:3]) == 2'd3));

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && $past(overflow)) |-> overflow);

    a_r7_pending_on_record: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr[4:3] == 2'd3) |=> fault_pending);

    a_r8_off_no_write: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !mem_wr_en);
endmodule

bind fltq_writer fltq_writer_chk #(.ADDR_W(ADDR_W), .MAX_LOG2N(MAX_LOG2N)) chk_i (.*);

// File: tb/fltq_writer_tb.sv
module fltq_writer_tb_top;
    localparam int ADDR_W = 64;
    localparam int MAXL   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic evt_valid = 1'b0;
    logic evt_ready;
    logic [11:0] evt_cause = '0;
    logic [5:0]  evt_ttyp = '0;
    logic        evt_priv = 1'b0, evt_pv = 1'b0;
    logic [19:0] evt_pasid = '0;
    logic [23:0] evt_devid = '0;
    logic [3:0]  evt_flags = '0;
    logic [63:0] evt_addr = '0, evt_gpa = '0;
    logic [63:0] cfg_base = 64'h0000_8000_1000_0000;
    logic [3:0]  cfg_log2n = 4'd3;
    logic [7:0]  sw_head = '0;
    logic        ip_clr = 1'b0;
    logic        mem_wr_en;
    logic [63:0] mem_wr_addr, mem_wr_data;
    logic [7:0]  tail;
    logic        overflow, fault_pending;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_tail = '0;
    logic       exp_ovf = 1'b0;

    always #2.5 clk = ~clk;

    fltq_writer #(.ADDR_W(ADDR_W), .MAX_LOG2N(MAXL)) dut_i (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(int k);
        case (k)
            0: return {evt_devid[22:0], evt_pasid, evt_pv, 1'b0, evt_priv, evt_ttyp, evt_cause};
            1: return {60'd0, evt_flags};
            2: return evt_addr;
            default: return (evt_cause == 12'd21 || evt_cause == 12'd23) ? evt_gpa : 64'd0;
        endcase
    endfunction

    function automatic logic [7:0] qmask();
        int l = (cfg_log2n > 4'(MAXL)) ? MAXL : int'(cfg_log2n);
        return 8'((1 << l) - 1);
    endfunction

    function automatic logic [11:0] pick_cause(int i);
        case (i % 12)
            0: return 12'd1;   1: return 12'd5;   2: return 12'd7;
            3: return 12'd12;  4: return 12'd13;  5: return 12'd15;
            6: return 12'd21;  7: return 12'd23;  8: return 12'd256;
            9: return 12'd258; 10: return 12'd259; default: return 12'd260;
        endcase
    endfunction

    task automatic load_event(logic [11:0] c);
        evt_cause = c;
        evt_ttyp  = 6'($urandom_range(9, 1));
        evt_priv  = 1'($urandom);
        evt_pv    = 1'($urandom);
        evt_pasid = 20'($urandom);
        evt_devid = 24'($urandom);
        evt_flags = 4'($urandom);
        evt_addr  = {$urandom, $urandom};
        evt_gpa   = {$urandom, $urandom};
    endtask

    // Drive one event at a negedge and check either the four-beat write or the drop.
    task automatic send(logic [11:0] c);
        logic [7:0] m = qmask();
        logic is_full = (((exp_tail + 8'd1) & m) == (sw_head & m));
        load_event(c);
        chk("R4 ready before event", 64'(evt_ready), 64'd1);
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        if (is_full) begin
            chk("R6 no write when full", 64'(mem_wr_en), 64'd0);
            chk("R6 overflow set", 64'(overflow), 64'd1);
            chk("R6 tail unchanged", 64'(tail), 64'(exp_tail));
            exp_ovf = 1'b1;
        end else begin
            for (int k = 0; k < 4; k++) begin
                chk("R4 write strobe", 64'(mem_wr_en), 64'd1);
                chk("R4 ready low", 64'(evt_ready), 64'd0);
                chk("R4 write address", mem_wr_addr,
                    cfg_base + 64'(exp_tail) * 64'd32 + 64'(k) * 64'd8);
                case (k)
                    0: chk("R1 word0", mem_wr_data, exp_word(0));
                    1: chk("R2 word1", mem_wr_data, exp_word(1));
                    default: chk("R3 word2/3", mem_wr_data, exp_word(k));
                endcase
                chk("R5 tail held mid-record", 64'(tail), 64'(exp_tail));
                @(negedge clk);
            end
            exp_tail = (exp_tail + 8'd1) & m;
            chk("R5 tail advanced", 64'(tail), 64'(exp_tail));
            chk("R7 pending set", 64'(fault_pending), 64'd1);
            chk("R4 write ends", 64'(mem_wr_en), 64'd0);
        end
        chk("R6 overflow sticky", 64'(overflow), 64'(exp_ovf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 tail", 64'(tail), 64'd0);
        chk("R9 overflow", 64'(overflow), 64'd0);
        chk("R9 pending", 64'(fault_pending), 64'd0);
        chk("R9 no write", 64'(mem_wr_en), 64'd0);
        chk("R9 ready", 64'(evt_ready), 64'd1);
        rst = 1'b0;
        enable = 1'b1;
        @(negedge clk);

        // R3 directed: G-stage cause keeps gpa, others zero it
        send(12'd21);
        send(12'd23);
        send(12'd5);
        send(12'd258);
        // fill 8-entry queue with head at 0: slots up to 7 used, then full
        send(12'd13);
        send(12'd1);
        send(12'd260);
        chk("R6 tail at last slot", 64'(tail), 64'd7);
        send(12'd15);                       // dropped
        chk("R6 overflow after drop", 64'(overflow), 64'd1);
        // software consumes, tail wraps to zero
        sw_head = 8'd3;
        send(12'd7);
        chk("R5 wrap to zero", 64'(tail), 64'd0);

        // R7 write-one-to-clear
        ip_clr = 1'b1;
        @(negedge clk);
        ip_clr = 1'b0;
        chk("R7 cleared by write one", 64'(fault_pending), 64'd0);

        // R7 set wins over clear at the same edge
        sw_head = 8'd0;
        load_event(12'd12);
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (3) @(negedge clk);
        ip_clr = 1'b1;                      // fourth beat visible now
        @(negedge clk);
        ip_clr = 1'b0;
        exp_tail = 8'd1;
        chk("R7 set wins over clear", 64'(fault_pending), 64'd1);

        // R8 disable: tail and overflow cleared, events ignored
        enable = 1'b0;
        @(negedge clk);
        chk("R8 tail zero when off", 64'(tail), 64'd0);
        chk("R8 overflow cleared when off", 64'(overflow), 64'd0);
        load_event(12'd13);
        evt_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 no write when off", 64'(mem_wr_en), 64'd0);
        end
        evt_valid = 1'b0;
        chk("R8 tail held when off", 64'(tail), 64'd0);
        exp_tail = '0;
        exp_ovf = 1'b0;

        // R8 abort mid-record
        enable = 1'b1;
        sw_head = 8'd0;
        @(negedge clk);
        load_event(12'd5);
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 abort stops write", 64'(mem_wr_en), 64'd0);
        chk("R8 abort keeps tail zero", 64'(tail), 64'd0);
        enable = 1'b1;
        @(negedge clk);
        chk("R8 ready after abort", 64'(evt_ready), 64'd1);

        // R5 clamp: log2 size above maximum behaves as maximum
        cfg_log2n = 4'd12;
        sw_head = 8'd0;
        send(12'd259);
        chk("R5 clamp advance", 64'(tail), 64'd1);

        // Random phase on a 16-entry queue
        cfg_log2n = 4'd4;
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        exp_tail = '0;
        exp_ovf = 1'b0;
        sw_head = 8'd0;
        @(negedge clk);
        for (int n = 0; n < 80; n++) begin
            if ($urandom_range(5, 0) == 0) sw_head = exp_tail;
            if ($urandom_range(3, 0) == 0) begin
                ip_clr = 1'b1;
                @(negedge clk);
                ip_clr = 1'b0;
                chk("R7 random clear", 64'(fault_pending), 64'd0);
            end
            send(pick_cause(int'($urandom_range(11, 0))));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule